// File: doc/BRIEF.md
# One-Time-Programmable Security Fuse Bank Controller

This block models a bank of one-time-programmable security fuses and the lock logic around them. The bank holds a 256-bit key field, a 32-bit user field and a 14-bit control field. Every fuse starts at 0 and can only be burned to 1. A program port ORs new bits into one field group at a time. A read port returns field contents, with the read locks applied. A separate output carries the user value to the internal fabric at all times.

Programming takes several cycles, and a busy flag covers that time. A request that hits a locked field, or that names an unknown group, is refused with a one-cycle error pulse and changes nothing. The write-lock bits and the configuration bits that reach the rest of the chip are copied into shadow registers once per reset. A newly burned write lock or configuration bit therefore acts only after the next reset. The two read-lock bits act as soon as they are burned. Each of them also blocks writes to the key and user fields.

Top module: `fuse_bank_ctrl`

## Requirements
- R1: Fuse bits only go from 0 to 1. Programming never clears a bit. Asserting `blank_n` low clears every fuse, which models a fresh device. `rst_n` leaves the fuse contents unchanged.
- R2: Group code 0 ORs `prog_key` into the key field and `prog_user[7:0]` into user bits [7:0] in one operation. It leaves user bits [31:8] untouched.
- R3: Group code 1 ORs `prog_user[31:8]` into user bits [31:8] only.
- R4: Group code 2 ORs `prog_ctrl` into the control field. The write-lock bits are bit 2 (key and user writes) and bit 5 (control writes). These two bits, and the configuration bits, are sampled into shadow registers on the first clock edge after `rst_n` rises. They take effect only from that sample onward.
- R5: Control bit 3 (key read lock) and control bit 4 (user read lock) act at once. While bit 3 is set, a key read returns all ones. While bit 4 is set, a user read returns ones in bits [31:0]. While either bit is set, group codes 0 and 1 are refused.
- R6: A refused request raises `prog_err` for exactly the one cycle after its edge, does not raise `prog_busy`, and leaves every fuse unchanged. A request is refused when it uses group code 3 or targets a locked group.
- R7: An accepted request holds `prog_busy` high for PROG_CYCLES cycles. The new fuse values are visible in the cycle where `prog_busy` falls.
- R8: A request made while `prog_busy` is high is ignored. It raises no error and changes no fuse.
- R9: `fab_user` always carries the stored 32-bit user value, whatever the user read lock.
- R10: A read of the control field is never masked. Read select codes are 0 for the key, 1 for the user field (zero-extended) and 2 for the control field. The configuration outputs carry the shadowed values of control bit 1 (`cfg_pcycle`), bit 8 (`cfg_key_only_boot`), bit 9 (`cfg_jtag_off`) and bit 10 (`cfg_bbkey_off`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| blank_n | input | 1 | Asynchronous active-low clear of the fuse array (fresh device) |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer and shadow registers |
| prog_req | input | 1 | Program request, sampled at each clock edge |
| prog_sel | input | 2 | Group code: 0 key plus user low, 1 user high, 2 control |
| prog_key | input | 256 | Key bits to burn |
| prog_user | input | 32 | User bits to burn |
| prog_ctrl | input | 14 | Control bits to burn |
| prog_busy | output | 1 | Programming in progress |
| prog_err | output | 1 | One-cycle pulse for a refused request |
| rd_sel | input | 2 | Read select: 0 key, 1 user, 2 control |
| rd_data | output | 256 | Read data with read locks applied |
| fab_user | output | 32 | Unmasked user value for the fabric |
| cfg_pcycle | output | 1 | Shadowed reconfiguration-needs-power-cycle bit |
| cfg_key_only_boot | output | 1 | Shadowed key-only secure boot bit |
| cfg_jtag_off | output | 1 | Shadowed scan-chain disable bit |
| cfg_bbkey_off | output | 1 | Shadowed battery-backed key disable bit |

## Verification
The error pulse is due in the cycle right after the request edge. The bench samples it at the next falling edge. Busy is then counted at falling edges until it drops, and the count must equal PROG_CYCLES. Fuse reads are combinational, so they are checked one time unit after `rd_sel` changes, once busy has fallen. The configuration outputs and write locks are checked two falling edges after reset release: both before a reset, when burned bits must have no effect yet, and after one, when they must act.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
   typedef enum logic [1:0] {
      OP_KEYLOW = 2'd0,
      OP_UPPER  = 2'd1,
      OP_CTRL   = 2'd2,
      OP_BAD    = 2'd3
   } fuse_op_e;

   // control-field bit positions that the lock logic decodes
   localparam int B_PCYCLE  = 1;
   localparam int B_WRLOCK  = 2;
   localparam int B_KEYRD   = 3;
   localparam int B_USRRD   = 4;
   localparam int B_CTLWR   = 5;
   localparam int B_KEYBOOT = 8;
   localparam int B_JTAG    = 9;
   localparam int B_BBKEY   = 10;
   localparam int MIN_CTRL_W = B_BBKEY + 1;

   // layout of the shadow vector
   localparam int S_PCYCLE  = 0;
   localparam int S_WRLOCK  = 1;
   localparam int S_CTLWR   = 2;
   localparam int S_KEYBOOT = 3;
   localparam int S_JTAG    = 4;
   localparam int S_BBKEY   = 5;
   localparam int SNAP_W    = 6;
endpackage

// File: rtl/fuse_store.sv
module fuse_store
   import fuse_pkg::*;
#(
   parameter int KEY_W  = 256,
   parameter int USER_W = 32,
   parameter int LOW_W  = 8,
   parameter int CTRL_W = 14
) (
   input  logic              clk,
   input  logic              blank_n,
   input  logic              commit,
   input  fuse_op_e          commit_op,
   input  logic [KEY_W-1:0]  set_key,
   input  logic [USER_W-1:0] set_user,
   input  logic [CTRL_W-1:0] set_ctrl,
   output logic [KEY_W-1:0]  key_q,
   output logic [USER_W-1:0] user_q,
   output logic [CTRL_W-1:0] ctrl_q
);
   always_ff @(posedge clk or negedge blank_n) begin
      if (!blank_n) begin
         key_q  <= '0;
         user_q <= '0;
         ctrl_q <= '0;
      end else if (commit) begin
         case (commit_op)
            OP_KEYLOW: begin
               key_q              <= key_q | set_key;
               user_q[LOW_W-1:0]  <= user_q[LOW_W-1:0] | set_user[LOW_W-1:0];
            end
            OP_UPPER:
               user_q[USER_W-1:LOW_W] <= user_q[USER_W-1:LOW_W] | set_user[USER_W-1:LOW_W];
            OP_CTRL:
               ctrl_q <= ctrl_q | set_ctrl;
            default: ;
         endcase
      end
   end

   AST_BITS_ONLY_SET: assert property (@(posedge clk) disable iff (!blank_n)
      ((key_q | $past(key_q)) == key_q) && ((user_q | $past(user_q)) == user_q) &&
      ((ctrl_q | $past(ctrl_q)) == ctrl_q)); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!blank_n)
      !commit |=> $stable({key_q, user_q, ctrl_q})); // R6
endmodule

// File: rtl/fuse_shadow.sv
module fuse_shadow #(
   parameter int SNAP_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SNAP_W-1:0] live,
   output logic [SNAP_W-1:0] shadow,
   output logic              ready
);
   // locked by default until the first post-reset sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '1;
         ready  <= 1'b0;
      end else if (!ready) begin
         shadow <= live;
         ready  <= 1'b1;
      end
   end

   AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready && $stable(shadow)); // R4
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
   import fuse_pkg::*;
#(
   parameter int KEY_W       = 256,
   parameter int USER_W      = 32,
   parameter int CTRL_W      = 14,
   parameter int PROG_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ready,
   input  logic              req,
   input  fuse_op_e          op,
   input  logic [KEY_W-1:0]  key,
   input  logic [USER_W-1:0] user,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic              keyuser_lock,
   input  logic              ctrl_lock,
   output logic              busy,
   output logic              err,
   output logic              commit,
   output fuse_op_e          op_q,
   output logic [KEY_W-1:0]  key_q,
   output logic [USER_W-1:0] user_q,
   output logic [CTRL_W-1:0] ctrl_q
);
   localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

   logic accept, legal, last;

   always_comb begin
      case (op)
         OP_KEYLOW, OP_UPPER: legal = !keyuser_lock;
         OP_CTRL:             legal = !ctrl_lock;
         default:             legal = 1'b0;
      endcase
   end

   assign accept = req && ready && !busy;
   assign commit = busy && last;

   generate
      if (PROG_CYCLES == 1) begin : g_single
         assign last = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 cnt <= '0;
            else if (accept && legal)   cnt <= CNT_W'(PROG_CYCLES - 1);
            else if (busy && cnt != '0) cnt <= cnt - 1'b1;
         end
         assign last = (cnt == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         err    <= 1'b0;
         op_q   <= OP_BAD;
         key_q  <= '0;
         user_q <= '0;
         ctrl_q <= '0;
      end else begin
         err <= accept && !legal;
         if (accept && legal) begin
            busy   <= 1'b1;
            op_q   <= op;
            key_q  <= key;
            user_q <= user;
            ctrl_q <= ctrl;
         end else if (commit) begin
            busy <= 1'b0;
         end
      end
   end

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last && req) |=> busy && !err); // R8

   AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy); // R6
endmodule

// File: rtl/fuse_bank_ctrl.sv
module fuse_bank_ctrl
   import fuse_pkg::*;
#(
   parameter int KEY_W       = 256,
   parameter int USER_W      = 32,
   parameter int LOW_W       = 8,
   parameter int CTRL_W      = 14,
   parameter int PROG_CYCLES = 4
) (
   input  logic              clk,
   input  logic              blank_n,
   input  logic              rst_n,
   input  logic              prog_req,
   input  logic [1:0]        prog_sel,
   input  logic [KEY_W-1:0]  prog_key,
   input  logic [USER_W-1:0] prog_user,
   input  logic [CTRL_W-1:0] prog_ctrl,
   output logic              prog_busy,
   output logic              prog_err,
   input  logic [1:0]        rd_sel,
   output logic [KEY_W-1:0]  rd_data,
   output logic [USER_W-1:0] fab_user,
   output logic              cfg_pcycle,
   output logic              cfg_key_only_boot,
   output logic              cfg_jtag_off,
   output logic              cfg_bbkey_off
);
   generate
      if (USER_W <= LOW_W) begin : g_bad_low
         $error("USER_W must exceed LOW_W");
      end
      if (CTRL_W < MIN_CTRL_W) begin : g_bad_ctrl
         $error("CTRL_W too small for lock bits");
      end
      if (KEY_W < USER_W || KEY_W < CTRL_W) begin : g_bad_key
         $error("KEY_W must be the widest field");
      end
      if (PROG_CYCLES < 1) begin : g_bad_cyc
         $error("PROG_CYCLES must be at least 1");
      end
   endgenerate

   logic [KEY_W-1:0]  key_q,  set_key;
   logic [USER_W-1:0] user_q, set_user;
   logic [CTRL_W-1:0] ctrl_q, set_ctrl;
   logic [SNAP_W-1:0] snap_live, snap;
   logic              ready, commit;
   fuse_op_e          commit_op;
   logic              key_rd_lock, usr_rd_lock, ku_lock, c_lock;

   assign snap_live = {ctrl_q[B_BBKEY], ctrl_q[B_JTAG], ctrl_q[B_KEYBOOT],
                       ctrl_q[B_CTLWR], ctrl_q[B_WRLOCK], ctrl_q[B_PCYCLE]};

   // read locks act at once; write locks come from the reset-time copy
   assign key_rd_lock = ctrl_q[B_KEYRD];
   assign usr_rd_lock = ctrl_q[B_USRRD];
   assign ku_lock     = snap[S_WRLOCK] | key_rd_lock | usr_rd_lock;
   assign c_lock      = snap[S_CTLWR];

   fuse_store #(.KEY_W(KEY_W), .USER_W(USER_W), .LOW_W(LOW_W), .CTRL_W(CTRL_W)) u_store (
      .clk(clk), .blank_n(blank_n), .commit(commit), .commit_op(commit_op),
      .set_key(set_key), .set_user(set_user), .set_ctrl(set_ctrl),
      .key_q(key_q), .user_q(user_q), .ctrl_q(ctrl_q));

   fuse_shadow #(.SNAP_W(SNAP_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .live(snap_live), .shadow(snap), .ready(ready));

   fuse_prog_seq #(.KEY_W(KEY_W), .USER_W(USER_W), .CTRL_W(CTRL_W),
                   .PROG_CYCLES(PROG_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .ready(ready), .req(prog_req),
      .op(fuse_op_e'(prog_sel)), .key(prog_key), .user(prog_user), .ctrl(prog_ctrl),
      .keyuser_lock(ku_lock), .ctrl_lock(c_lock),
      .busy(prog_busy), .err(prog_err), .commit(commit), .op_q(commit_op),
      .key_q(set_key), .user_q(set_user), .ctrl_q(set_ctrl));

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         2'd0: rd_data = key_rd_lock ? {KEY_W{1'b1}} : key_q;
         2'd1: rd_data[USER_W-1:0] = usr_rd_lock ? {USER_W{1'b1}} : user_q;
         2'd2: rd_data[CTRL_W-1:0] = ctrl_q;
         default: ;
      endcase
   end

   assign fab_user          = user_q;
   assign cfg_pcycle        = snap[S_PCYCLE];
   assign cfg_key_only_boot = snap[S_KEYBOOT];
   assign cfg_jtag_off      = snap[S_JTAG];
   assign cfg_bbkey_off     = snap[S_BBKEY];

   AST_LOCKED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req && ready && !prog_busy && prog_sel == 2'd2 && c_lock) |=>
      prog_err && !prog_busy); // R6
endmodule

// File: tb/tb_fuse_bank_ctrl.sv
module tb_fuse_bank_ctrl;
   localparam int KEY_W = 256, USER_W = 32, CTRL_W = 14, PROG_CYCLES = 4;

   logic              clk = 1'b0, blank_n = 1'b0, rst_n = 1'b0, prog_req = 1'b0;
   logic [1:0]        prog_sel = 2'd0, rd_sel = 2'd0;
   logic [KEY_W-1:0]  prog_key = '0;
   logic [USER_W-1:0] prog_user = '0;
   logic [CTRL_W-1:0] prog_ctrl = '0;
   logic              prog_busy, prog_err;
   logic [KEY_W-1:0]  rd_data;
   logic [USER_W-1:0] fab_user;
   logic              cfg_pcycle, cfg_key_only_boot, cfg_jtag_off, cfg_bbkey_off;

   int checks = 0, fails = 0;
   logic [KEY_W-1:0]  mk;
   logic [USER_W-1:0] mu;
   logic [CTRL_W-1:0] mc;

   localparam logic [KEY_W-1:0] K1 = {8{32'h0F0F_1234}};
   localparam logic [KEY_W-1:0] K2 = {8{32'h8000_0001}};

   fuse_bank_ctrl #(.PROG_CYCLES(PROG_CYCLES)) dut (.*);

   always #4 clk = ~clk;

   task automatic chk(string tag, logic [KEY_W-1:0] act, logic [KEY_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic do_blank();
      @(negedge clk) begin blank_n = 1'b0; rst_n = 1'b0; end
      @(negedge clk) blank_n = 1'b1;
      mk = '0; mu = '0; mc = '0;
      do_reset();
   endtask

   task automatic prog(logic [1:0] op, logic [KEY_W-1:0] k, logic [USER_W-1:0] u,
                       logic [CTRL_W-1:0] c, bit ok, string tag);
      int n;
      @(negedge clk);
      prog_sel = op; prog_key = k; prog_user = u; prog_ctrl = c; prog_req = 1'b1;
      @(negedge clk) prog_req = 1'b0;
      chk({tag, " err"}, KEY_W'(prog_err), KEY_W'(!ok));
      if (ok) begin
         n = 0;
         while (prog_busy && n < 50) begin n++; @(negedge clk); end
         chk("R7 busy length", KEY_W'(n), KEY_W'(PROG_CYCLES));
         case (op)
            2'd0: begin mk = mk | k; mu[7:0] = mu[7:0] | u[7:0]; end
            2'd1: mu[31:8] = mu[31:8] | u[31:8];
            2'd2: mc = mc | c;
            default: ;
         endcase
      end else begin
         chk({tag, " busy"}, KEY_W'(prog_busy), '0);
      end
   endtask

   task automatic rd_check(string tag);
      rd_sel = 2'd0; #1;
      chk({tag, " key"}, rd_data, mc[3] ? {KEY_W{1'b1}} : mk);
      rd_sel = 2'd1; #1;
      chk({tag, " user"}, rd_data, KEY_W'(mc[4] ? 32'hFFFF_FFFF : mu));
      rd_sel = 2'd2; #1;
      chk({tag, " R10 ctrl"}, rd_data, KEY_W'(mc));
      chk({tag, " R9 fab"}, KEY_W'(fab_user), KEY_W'(mu));
   endtask

   task automatic t_reset_state();
      chk("R1 busy after blank", KEY_W'(prog_busy), '0);
      chk("R6 err after blank", KEY_W'(prog_err), '0);
      chk("R10 cfg after blank", KEY_W'({cfg_pcycle, cfg_key_only_boot, cfg_jtag_off, cfg_bbkey_off}), '0);
      rd_check("R1 blank");
   endtask

   task automatic t_key_and_user();
      prog(2'd0, K1, 32'hAABB_CCDD, '0, 1'b1, "R2");
      rd_check("R2");
      prog(2'd1, '0, 32'h1234_5678, '0, 1'b1, "R3");
      rd_check("R3");
      prog(2'd0, K2, 32'h0000_0022, '0, 1'b1, "R1 or");
      prog(2'd1, '0, 32'h0000_0000, '0, 1'b1, "R1 zero");
      rd_check("R1 only-set");
   endtask

   task automatic t_busy_ignore();
      int n;
      @(negedge clk);
      prog_sel = 2'd2; prog_ctrl = 14'(1 << 1); prog_req = 1'b1;
      @(negedge clk) prog_req = 1'b0;
      chk("R8 busy set", KEY_W'(prog_busy), KEY_W'(1));
      prog_sel = 2'd1; prog_user = 32'hFFFF_FF00; prog_req = 1'b1;
      @(negedge clk) prog_req = 1'b0;
      chk("R8 no err", KEY_W'(prog_err), '0);
      n = 0;
      while (prog_busy && n < 50) begin n++; @(negedge clk); end
      mc = mc | 14'(1 << 1);
      rd_check("R8 ignored");
   endtask

   task automatic t_delayed_locks();
      prog(2'd2, '0, '0, 14'((1 << 2) | (1 << 9)), 1'b1, "R4");
      chk("R4 jtag before reset", KEY_W'(cfg_jtag_off), '0);
      prog(2'd1, '0, 32'h0000_0100, '0, 1'b1, "R4 write before reset");
      do_reset();
      rd_check("R1 persist");
      chk("R10 jtag", KEY_W'(cfg_jtag_off), KEY_W'(1));
      chk("R10 pcycle", KEY_W'(cfg_pcycle), KEY_W'(1));
      prog(2'd0, K1, 32'h0000_0001, '0, 1'b0, "R6 key locked");
      prog(2'd1, '0, 32'h8000_0000, '0, 1'b0, "R6 upper locked");
      prog(2'd3, '0, '0, '0, 1'b0, "R6 bad code");
      rd_check("R6 unchanged");
   endtask

   task automatic t_read_locks();
      do_blank();
      prog(2'd0, K1, 32'h0000_005A, '0, 1'b1, "R2");
      prog(2'd1, '0, 32'hC300_0000, '0, 1'b1, "R3");
      prog(2'd2, '0, '0, 14'(1 << 3), 1'b1, "R5");
      rd_check("R5 key lock");
      prog(2'd1, '0, 32'h00FF_0000, '0, 1'b0, "R5 write blocked");
      prog(2'd2, '0, '0, 14'(1 << 4), 1'b1, "R5");
      rd_check("R5 user lock");
      chk("R9 fab unmasked", KEY_W'(fab_user), KEY_W'(32'hC300_005A));
   endtask

   task automatic t_ctrl_lock();
      do_blank();
      prog(2'd2, '0, '0, 14'(1 << 5), 1'b1, "R4");
      prog(2'd2, '0, '0, 14'(1 << 8), 1'b1, "R4 ctrl before reset");
      chk("R4 boot before reset", KEY_W'(cfg_key_only_boot), '0);
      do_reset();
      chk("R10 key-only boot", KEY_W'(cfg_key_only_boot), KEY_W'(1));
      prog(2'd2, '0, '0, 14'(1 << 10), 1'b0, "R4 ctrl locked");
      chk("R10 bbkey stays", KEY_W'(cfg_bbkey_off), '0);
      prog(2'd0, K2, 32'h0000_0011, '0, 1'b1, "R2 key open");
      rd_check("R4 final");
   endtask

   initial begin
      #(8 * 100000);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      do_blank();
      t_reset_state();
      t_key_and_user();
      t_busy_ignore();
      t_delayed_locks();
      t_read_locks();
      t_ctrl_lock();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule